// File: doc/BRIEF.md
# ALU Status Flag Unit

This block keeps the flags word that sits beside a 16-bit ALU. Each cycle the ALU presents the class of the operation it just finished, its two operands, its result, the operand size (byte or word) and, for shifts and rotates, the bit that left the operand. When an update is requested, the unit derives the six status flags from these values and registers them.

The three control flags (string direction, interrupt enable, single-step trap) never follow ALU results. They change only through explicit set and clear commands or when the whole word is loaded at once, for example when a saved flags image is restored. The packed flags word is always available as a registered output with a fixed layout.

Carry, borrow, nibble carry and overflow are recovered from the operands and the result alone. The unit therefore needs no carry-in port and works the same for add-with-carry and subtract-with-borrow.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset the flags word reads 16'h0002: every flag is 0 and bit 1 is 1.
- R2: Layout of the flags word: carry bit 0, parity bit 2, nibble carry bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt enable bit 9, direction bit 10, overflow bit 11. Bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R3: With upd_en high and op_class 2'b00 (add), carry is the carry out of the top bit, nibble carry is the carry from bit 3 into bit 4, and overflow is set when the signed sum does not fit the operand size.
- R4: With op_class 2'b01 (subtract), carry holds the borrow out of the top bit, nibble carry holds the borrow into bit 4 from bit 3, and overflow is set when the signed difference does not fit.
- R5: For every class, sign equals the top bit of the result, and zero is 1 exactly when the result, at the operand size, is all zeros.
- R6: For every class, parity is 1 when bits 7:0 of the result hold an even number of ones.
- R7: When size_word is 0 (byte), bit 7 is the top bit and bits 15:8 of the operands and the result have no effect. When size_word is 1, bit 15 is the top bit.
- R8: With op_class 2'b10 (logic), carry and overflow become 0 and the nibble carry keeps its value. Sign, zero and parity update.
- R9: With op_class 2'b11 (shift or rotate), carry takes shift_out. Sign, zero and parity update, and the nibble carry and overflow keep their values.
- R10: ctl_set and ctl_clr act per flag, with bit 0 for direction, bit 1 for interrupt enable and bit 2 for trap. Clear wins when both are given for one flag. Status updates never change the control flags.
- R11: When load_en is high, the word takes load_data in every flag position. This overrides any update, set or clear given in the same cycle.
- R12: When upd_en and load_en are both low, all six status flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_en | input | 1 | Update the status flags from this cycle's operation |
| op_class | input | 2 | 00 add, 01 subtract, 10 logic, 11 shift/rotate |
| size_word | input | 1 | 1 word operands, 0 byte operands |
| opnd_a | input | 16 | First ALU operand (minuend for subtract) |
| opnd_b | input | 16 | Second ALU operand (subtrahend for subtract) |
| alu_result | input | 16 | ALU result for this operation |
| shift_out | input | 1 | Last bit shifted or rotated out |
| ctl_set | input | 3 | Set control flags: [0] direction, [1] interrupt, [2] trap |
| ctl_clr | input | 3 | Clear control flags, same bit order |
| load_en | input | 1 | Load the whole flags word |
| load_data | input | 16 | Word image to load |
| flags_word | output | 16 | Packed flags word |

## Verification
The assertions check on every cycle the behaviour that holds whatever the data. The fixed bits keep their values. A load replaces the word. Logic operations clear carry and overflow and keep the nibble carry. Shifts copy shift_out into carry. Control flags hold without commands, and status flags hold without updates. The carry, borrow, nibble-carry, overflow and parity values for particular operand pairs, and the fact that the upper byte has no effect in byte mode, can only be shown by the bench. It sweeps byte and word operand grids and compares each result with flags it computes itself using integer arithmetic.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_SHIFT = 2'b11
  } op_class_e;

  // R2: positions of flags in the packed word
  localparam int POS_C = 0;
  localparam int POS_P = 2;
  localparam int POS_A = 4;
  localparam int POS_Z = 6;
  localparam int POS_S = 7;
  localparam int POS_T = 8;
  localparam int POS_I = 9;
  localparam int POS_D = 10;
  localparam int POS_O = 11;

  localparam logic [15:0] WORD_ONES = 16'h0002;

  typedef struct packed {
    logic c;
    logic p;
    logic a;
    logic z;
    logic s;
    logic o;
  } status_t;

  typedef struct packed {
    logic t;
    logic i;
    logic d;
  } ctl_t;

  function automatic logic even_par8(input logic [7:0] v);
    return ~(^v);
  endfunction

  // carry out of one bit position, recovered from operands and result
  function automatic logic add_carry(input logic am, input logic bm, input logic rm);
    return (am & bm) | ((am | bm) & ~rm);
  endfunction

  // borrow out of one bit position for a - b, recovered from result
  function automatic logic sub_borrow(input logic am, input logic bm, input logic rm);
    return (~am & bm) | ((~am | bm) & rm);
  endfunction

  function automatic logic signed_ovf(input logic is_sub, input logic am,
                                      input logic bm, input logic rm);
    return is_sub ? ((am != bm) && (rm != am)) : ((am == bm) && (rm != am));
  endfunction

  function automatic logic [15:0] pack_word(input status_t st, input ctl_t ct);
    logic [15:0] w;
    w        = WORD_ONES;
    w[POS_C] = st.c;
    w[POS_P] = st.p;
    w[POS_A] = st.a;
    w[POS_Z] = st.z;
    w[POS_S] = st.s;
    w[POS_O] = st.o;
    w[POS_T] = ct.t;
    w[POS_I] = ct.i;
    w[POS_D] = ct.d;
    return w;
  endfunction

endpackage

// File: rtl/afu_arith_flags.sv
module afu_arith_flags
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              is_sub,
  input  logic              size_word,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  output logic              carry,
  output logic              nib_carry,
  output logic              ovf
);
  localparam int WMSB = DATA_W - 1;
  localparam int BMSB = BYTE_W - 1;

  logic am, bm, rm;

  always_comb begin
    am = size_word ? a[WMSB] : a[BMSB];
    bm = size_word ? b[WMSB] : b[BMSB];
    rm = size_word ? r[WMSB] : r[BMSB];
    carry     = is_sub ? sub_borrow(am, bm, rm) : add_carry(am, bm, rm);
    // carry or borrow into bit NIB_W is visible as the xor of that column
    nib_carry = a[NIB_W] ^ b[NIB_W] ^ r[NIB_W];
    ovf       = signed_ovf(is_sub, am, bm, rm);
  end
endmodule

// File: rtl/afu_result_flags.sv
module afu_result_flags
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              size_word,
  input  logic [DATA_W-1:0] r,
  output logic              sign,
  output logic              zero,
  output logic              parity
);
  always_comb begin
    sign   = size_word ? r[DATA_W-1] : r[BYTE_W-1];
    zero   = size_word ? (r == '0) : (r[BYTE_W-1:0] == '0);
    parity = even_par8(r[7:0]);
  end
endmodule

// File: rtl/afu_ctl_flags.sv
module afu_ctl_flags
  import afu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  ctl_t       load_val,
  input  logic [2:0] set_cmd,
  input  logic [2:0] clr_cmd,
  output ctl_t       ctl_q
);
  logic [2:0] cur, nxt;

  assign cur = {ctl_q.t, ctl_q.i, ctl_q.d};

  always_comb begin
    if (load_en) nxt = {load_val.t, load_val.i, load_val.d};
    else         nxt = (cur | set_cmd) & ~clr_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= '{t: nxt[2], i: nxt[1], d: nxt[0]};
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic              size_word,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              shift_out,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  input  logic              load_en,
  input  logic [15:0]       load_data,
  output logic [15:0]       flags_word
);
  op_class_e op;
  assign op = op_class_e'(op_class);

  // named events for the checker
  logic ev_load, ev_update, ev_arith, ev_logic, ev_shift;
  assign ev_load   = load_en;
  assign ev_update = upd_en & ~load_en;
  assign ev_arith  = ev_update & ((op == OP_ADD) | (op == OP_SUB));
  assign ev_logic  = ev_update & (op == OP_LOGIC);
  assign ev_shift  = ev_update & (op == OP_SHIFT);

  logic ar_carry, ar_nib, ar_ovf;
  logic rs_sign, rs_zero, rs_par;

  afu_arith_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_arith (
    .is_sub    (op == OP_SUB),
    .size_word (size_word),
    .a         (opnd_a),
    .b         (opnd_b),
    .r         (alu_result),
    .carry     (ar_carry),
    .nib_carry (ar_nib),
    .ovf       (ar_ovf)
  );

  afu_result_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_result (
    .size_word (size_word),
    .r         (alu_result),
    .sign      (rs_sign),
    .zero      (rs_zero),
    .parity    (rs_par)
  );

  ctl_t ctl_q, ctl_ld;
  assign ctl_ld = '{t: load_data[POS_T], i: load_data[POS_I], d: load_data[POS_D]};

  afu_ctl_flags u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (ctl_ld),
    .set_cmd  (ctl_set),
    .clr_cmd  (ctl_clr),
    .ctl_q    (ctl_q)
  );

  status_t st_q, st_nxt, st_ld;
  assign st_ld = '{c: load_data[POS_C], p: load_data[POS_P], a: load_data[POS_A],
                   z: load_data[POS_Z], s: load_data[POS_S], o: load_data[POS_O]};

  always_comb begin
    st_nxt = st_q;
    if (ev_load) begin
      st_nxt = st_ld;
    end else if (ev_update) begin
      st_nxt.s = rs_sign;
      st_nxt.z = rs_zero;
      st_nxt.p = rs_par;
      unique case (op)
        OP_ADD, OP_SUB: begin
          st_nxt.c = ar_carry;
          st_nxt.a = ar_nib;
          st_nxt.o = ar_ovf;
        end
        OP_LOGIC: begin
          st_nxt.c = 1'b0;
          st_nxt.o = 1'b0;
        end
        OP_SHIFT: begin
          st_nxt.c = shift_out;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_nxt;
  end

  assign flags_word = pack_word(st_q, ctl_q);
endmodule

// File: rtl/afu_checker.sv
module afu_checker
  import afu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ev_load,
  input logic        ev_update,
  input logic        ev_logic,
  input logic        ev_shift,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic        shift_out,
  input logic [15:0] load_data,
  input logic [15:0] flags_word
);
  localparam logic [15:0] LOAD_MASK = 16'h0FD5;

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_word[1] == 1'b1) && (flags_word[5] == 1'b0) &&
    (flags_word[3] == 1'b0) && (flags_word[15:12] == 4'h0));

  a_r11_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> flags_word == (($past(load_data) & LOAD_MASK) | WORD_ONES));

  a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_logic |=> (flags_word[POS_C] == 1'b0) && (flags_word[POS_O] == 1'b0));

  a_r8_logic_keeps_aux: assert property (@(posedge clk) disable iff (!rst_n)
    ev_logic |=> $stable(flags_word[POS_A]));

  a_r9_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> (flags_word[POS_C] == $past(shift_out)) &&
                 $stable(flags_word[POS_A]) && $stable(flags_word[POS_O]));

  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && ctl_set == 3'b0 && ctl_clr == 3'b0) |=> $stable(flags_word[10:8]));

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && ctl_clr[0] && ctl_set[0]) |=> flags_word[POS_D] == 1'b0);

  a_r12_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && !ev_update) |=>
      $stable(flags_word[POS_C]) && $stable(flags_word[POS_P]) && $stable(flags_word[POS_A]) &&
      $stable(flags_word[POS_Z]) && $stable(flags_word[POS_S]) && $stable(flags_word[POS_O]));
endmodule

bind alu_flag_unit afu_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_load    (ev_load),
  .ev_update  (ev_update),
  .ev_logic   (ev_logic),
  .ev_shift   (ev_shift),
  .ctl_set    (ctl_set),
  .ctl_clr    (ctl_clr),
  .shift_out  (shift_out),
  .load_data  (load_data),
  .flags_word (flags_word)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [1:0]  op_class = 2'b00;
  logic        size_word = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, alu_result = '0;
  logic        shift_out = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic        load_en = 1'b0;
  logic [15:0] load_data = '0;
  logic [15:0] flags_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of each flag
  logic mc, mp, ma, mz, ms, mo, mt, mi, md;

  always #2 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .size_word(size_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_result(alu_result), .shift_out(shift_out), .ctl_set(ctl_set),
    .ctl_clr(ctl_clr), .load_en(load_en), .load_data(load_data),
    .flags_word(flags_word)
  );

  function automatic logic [15:0] model_word();
    logic [15:0] w = 16'h0002;
    w[0] = mc; w[2] = mp; w[4] = ma; w[6] = mz; w[7] = ms;
    w[8] = mt; w[9] = mi; w[10] = md; w[11] = mo;
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick_and_check(input string tag);
    @(posedge clk); #1;
    check(tag, flags_word, model_word());
    upd_en = 0; load_en = 0; ctl_set = '0; ctl_clr = '0;
  endtask

  // apply one ALU operation and update the model from integer arithmetic
  task automatic do_op(input int cls, input bit wd, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] r,
                       input logic so, input string tag);
    int m, top, ua, ub, ur, sa, sb, sr;
    m   = wd ? 32'hFFFF : 32'hFF;
    top = wd ? 32'h8000 : 32'h80;
    ua = a & m; ub = b & m; ur = r & m;
    sa = (ua >= top) ? ua - 2*top : ua;
    sb = (ub >= top) ? ub - 2*top : ub;
    if (cls == 0) begin
      mc = (ua + ub) > m;
      ma = ((ua & 15) + (ub & 15)) > 15;
      sr = sa + sb;
      mo = (sr >= top) || (sr < -top);
    end else if (cls == 1) begin
      mc = ua < ub;
      ma = (ua & 15) < (ub & 15);
      sr = sa - sb;
      mo = (sr >= top) || (sr < -top);
    end else if (cls == 2) begin
      mc = 0; mo = 0;
    end else begin
      mc = so;
    end
    ms = ur >= top;
    mz = ur == 0;
    mp = ($countones(r[7:0]) % 2) == 0;
    upd_en = 1; op_class = 2'(cls); size_word = wd;
    opnd_a = a; opnd_b = b; alu_result = r; shift_out = so;
    tick_and_check(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] a8, b8, junk;
    logic [15:0] aw, bw;
    {mc, mp, ma, mz, ms, mo, mt, mi, md} = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", flags_word, 16'h0002);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 after release", flags_word, 16'h0002);

    // R3 and R4 byte sweep, with junk in the upper byte (R7)
    for (int i = 0; i < 256; i += 5) begin
      for (int j = 0; j < 256; j += 5) begin
        a8 = 8'(i); b8 = 8'(j); junk = 8'(i * 7 + j * 13 + 1);
        do_op(0, 0, {junk, a8}, {~junk, b8}, {junk ^ 8'h5A, 8'(a8 + b8)}, 0, "R3 R5 R6 R7 byte add");
        do_op(1, 0, {~junk, a8}, {junk, b8}, {junk, 8'(a8 - b8)}, 0, "R4 R5 R6 R7 byte sub");
      end
    end
    // corner bytes
    do_op(0, 0, 16'h0080, 16'h0080, 16'h0000, 0, "R3 R5 byte overflow to zero");
    do_op(1, 0, 16'h0000, 16'h0001, 16'h00FF, 0, "R4 byte borrow");

    // word sweep
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        aw = 16'(i * 1031 + (i & 1) * 16'h8000);
        bw = 16'(j * 977 + (j & 2) * 16'h4000);
        do_op(0, 1, aw, bw, 16'(aw + bw), 0, "R3 R5 R6 word add");
        do_op(1, 1, aw, bw, 16'(aw - bw), 0, "R4 R5 R6 word sub");
      end
    end
    do_op(0, 1, 16'h7FFF, 16'h0001, 16'h8000, 0, "R3 word signed overflow");
    do_op(1, 1, 16'h8000, 16'h0001, 16'h7FFF, 0, "R4 word signed overflow");
    do_op(0, 1, 16'hFFFF, 16'h0001, 16'h0000, 0, "R3 R5 word carry zero");
    do_op(0, 1, 16'h0100, 16'h0000, 16'h0100, 0, "R7 word upper byte nonzero");

    // R8 logic: set A first, then see it held
    do_op(0, 0, 16'h000F, 16'h0001, 16'h0010, 0, "R3 aux set");
    for (int i = 0; i < 256; i += 3) begin
      aw = 16'(i * 301);
      bw = 16'(i * 97 + 5);
      do_op(2, 1, aw, bw, aw & bw, 0, "R8 logic and");
      do_op(2, 0, aw, bw, aw ^ bw, 0, "R8 logic xor byte");
    end

    // R9 shift: set O and A first, shifts must keep them
    do_op(0, 0, 16'h007F, 16'h0001, 16'h0080, 0, "R3 overflow set");
    for (int i = 0; i < 256; i++) begin
      a8 = 8'(i);
      do_op(3, 0, {8'hC3, a8}, 16'h0001, {8'h3C, a8[6:0], 1'b0}, a8[7], "R9 byte shift");
      do_op(3, 1, {a8, a8}, 16'h0001, {a8[6:0], a8, 1'b0}, a8[7], "R9 word shift");
    end

    // R10 control commands
    ctl_set = 3'b001; md = 1; tick_and_check("R10 set direction");
    ctl_set = 3'b110; mi = 1; mt = 1; tick_and_check("R10 set interrupt trap");
    ctl_set = 3'b010; ctl_clr = 3'b010; mi = 0; tick_and_check("R10 clear wins");
    do_op(2, 1, 16'h0000, 16'h0000, 16'h0000, 0, "R10 update leaves control");
    ctl_clr = 3'b101; md = 0; mt = 0; tick_and_check("R10 clear direction trap");

    // R11 load beats everything
    load_en = 1; load_data = 16'hFFFF; upd_en = 1; op_class = 2'b10; ctl_clr = 3'b111;
    {mc, mp, ma, mz, ms, mo, mt, mi, md} = '1;
    tick_and_check("R11 R2 load all ones");
    check("R2 all ones image", flags_word, 16'h0FD7);
    load_en = 1; load_data = 16'h0000; ctl_set = 3'b111;
    {mc, mp, ma, mz, ms, mo, mt, mi, md} = '0;
    tick_and_check("R11 load zeros");
    load_en = 1; load_data = 16'h0A55; 
    mc = 1; mp = 1; ma = 1; mz = 1; ms = 0; mo = 1; mt = 0; mi = 1; md = 0;
    tick_and_check("R11 R2 load pattern");

    // R12 hold with no update
    upd_en = 0; op_class = 2'b00; size_word = 0;
    opnd_a = 16'h00FF; opnd_b = 16'h0001; alu_result = 16'h0000; shift_out = 1;
    tick_and_check("R12 hold add inputs");
    op_class = 2'b10;
    tick_and_check("R12 hold logic inputs");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule